// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer/Counter

This block holds two 16-bit timer/counter halves, A and B, behind a small 32-bit register bus. Each half keeps its own control, reload and count state and takes start, stop and reload commands through a write-only run register. A half can work as a timer that ticks on the module clock, optionally gated by an external level. It can also work as an event counter that ticks on selected edges of an external pin. Either way it counts up or down, and it runs cyclically or stops after one expiry.

The pin path of each half can be synchronised through two flops and inverted before the edge is chosen. A join flag, present only in half A, chains the halves into one 32-bit unit. Half A then holds the low word and half B the high word, and half A's control and run registers govern the whole unit. Each half has a pending flag that is set on expiry and cleared by writing one. An enable mask gates the flags onto a single interrupt line.

Top module: `tmr_pair16`

## Requirements
- R1: After reset, every control, running, reload, count, interrupt-enable and pending bit is zero and `irq` is low.
- R2: Byte offsets on `bus_addr` (half A, then half B at +4): control 0x10/0x14, run 0x18/0x1C (write-only, reads 0), reload 0x20/0x24, count 0x28/0x2C (read-only), interrupt enable 0xF4, pending 0xFC. Control bit 0 is the read-only running flag. Control bit 1 selects up counting, bit 2 selects event-counter mode and bit 3 selects one-shot. Bit 4 is join and exists only in half A; it reads 0 in half B. Bit 5 inverts the pin, bits 7:6 select the edge and bit 8 enables the synchroniser. Bit 9 gates the timer by the pin level, and bit 10 makes the counter use the other half's pin. The reload register reads back the low 16 bits written.
- R3: A down-counting half in timer mode decrements by one on every clock while running. A tick that finds the count at 0 loads the reload value instead and marks an expiry.
- R4: An up-counting half increments by one per tick. A tick that finds the count at 0xFFFF loads the reload value and marks an expiry.
- R5: A run write with bit 0 set starts the half. If bit 2 is also set, the count is loaded from reload on the same edge; without bit 2, counting resumes from the held count. The edge that takes a run write never steps the count.
- R6: A run write with bit 1 set clears the running flag on that edge, and the count then holds its value. When bit 1 and bit 0 are written together, stop wins and no load takes place.
- R7: In one-shot mode an expiry clears the running flag, and the count stays at the reload value.
- R8: In event-counter mode the half ticks on edges of the conditioned pin. The edge field codes 0 as none, 1 as rising, 2 as falling and 3 as both. Inversion is applied before the edge is chosen. Without the synchroniser, a pin change is counted on the first rising clock edge after it. Bit 10 selects `ext_in[1]` for half A and `ext_in[0]` for half B.
- R9: With control bit 8 set, a pin change is counted two clock edges later than without it.
- R10: In timer mode with bit 9 set, the half ticks only in cycles where the conditioned pin level is 1.
- R11: With half A's join bit set, the pair counts as one 32-bit value in which half B holds the upper 16 bits of reload and count. Half A's direction, one-shot and run bits govern the unit. Run writes to half B are ignored and half B reads as not running. An expiry sets only pending bit 0.
- R12: Pending bit 0 (half A) and bit 1 (half B) are set on expiry. Writing 1 to a bit at 0xFC clears it, but an expiry in the same cycle wins. `irq` is high while any pending bit has its enable bit at 0xF4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ext_in | input | 2 | External pins; bit 0 belongs to half A, bit 1 to half B |
| irq | output | 1 | Interrupt, OR of enabled pending bits |

## Verification
The bench hits the count boundaries in both directions: the tick at 0 going down and the tick at 0xFFFF going up, including a reload value of 0. A design with an off-by-one terminal test would end a run one count away from the expected value, or it would raise pending a tick early or late. The 32-bit join is driven through the borrow from the low word into the high word and through a full 65536-tick lap. A design that reloaded half A on its own wrap would never reach the 32-bit expiry. The pin path is checked edge by edge with and without the synchroniser, and a design with a wrong latency would show the count changing a cycle early or late. The run-command checks cover stop-beats-start, resume versus reload, and the one-shot drop of the running flag, each of which would show up as a wrong count or a wrong running flag.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int NUM_HALF    = 2;
  localparam int HALF_STRIDE = 4;
  localparam int OFF_CTRL    = 'h10;
  localparam int OFF_RUN     = 'h18;
  localparam int OFF_RELOAD  = 'h20;
  localparam int OFF_COUNT   = 'h28;
  localparam int OFF_IEN     = 'hF4;
  localparam int OFF_PEND    = 'hFC;

  localparam int RUN_START = 0;
  localparam int RUN_STOP  = 1;
  localparam int RUN_LOAD  = 2;

  localparam int CTRL_LSB = 1;
  localparam int CTRL_MSB = 10;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  // Packed from bit 10 down to bit 1 of the control register.
  typedef struct packed {
    logic      src_nbr;
    logic      gate_ext;
    logic      sync_en;
    edge_sel_e edge_sel;
    logic      inv;
    logic      join_b;
    logic      one_shot;
    logic      evt_mode;
    logic      up;
  } ctrl_t;

  function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
    case (sel)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tp_in_cond.sv
module tp_in_cond
  import tp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  logic      sync_en,
  input  logic      inv,
  input  edge_sel_e edge_sel,
  output logic      lvl,
  output logic      ev
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= lvl;
    end
  end

  assign lvl = (sync_en ? s2_q : pin) ^ inv;
  assign ev  = edge_hit(edge_sel, lvl, prev_q);
endmodule

// File: rtl/tp_half.sv
module tp_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         wrap,
  input  logic         up,
  input  logic [W-1:0] rld,
  output logic [W-1:0] cnt,
  output logic         term
);
  function automatic logic [W-1:0] f_next(logic [W-1:0] c, logic u);
    return u ? c + 1'b1 : c - 1'b1;
  endfunction

  function automatic logic f_term(logic [W-1:0] c, logic u);
    return u ? (&c) : (c == '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= rld;
    else if (step) cnt <= wrap ? rld : f_next(cnt, up);
  end

  assign term = f_term(cnt, up);
endmodule

// File: rtl/tmr_pair16.sv
module tmr_pair16
  import tp_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [1:0]    ext_in,
  output logic          irq
);
  localparam int CW = CTRL_MSB - CTRL_LSB + 1;

  ctrl_t               ctrl_q [NUM_HALF];
  logic [W-1:0]        rld_q  [NUM_HALF];
  logic [W-1:0]        cnt    [NUM_HALF];
  logic [NUM_HALF-1:0] en_q, ien_q, pend_q;

  logic [NUM_HALF-1:0] wr_ctrl, wr_rld, wr_run_raw, run_wr;
  logic [NUM_HALF-1:0] lvl, ev, tick, term, step, load, wrap, up_eff, expire;
  logic                wr_ien, wr_clr, joined;
  logic                cmd_start, cmd_stop, cmd_load;
  ctrl_t               ctrl_wval;
  logic                unused_wdata;

  assign ctrl_wval = ctrl_t'(bus_wdata[CTRL_MSB:CTRL_LSB]);
  assign cmd_start = bus_wdata[RUN_START];
  assign cmd_stop  = bus_wdata[RUN_STOP];
  assign cmd_load  = bus_wdata[RUN_LOAD];
  assign wr_ien    = bus_wr && (bus_addr == AW'(OFF_IEN));
  assign wr_clr    = bus_wr && (bus_addr == AW'(OFF_PEND));
  assign joined    = ctrl_q[0].join_b;
  assign unused_wdata = ^bus_wdata[DW-1:CTRL_MSB+1];

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic pin_sel;
    assign wr_ctrl[h]    = bus_wr && (bus_addr == AW'(OFF_CTRL   + h*HALF_STRIDE));
    assign wr_run_raw[h] = bus_wr && (bus_addr == AW'(OFF_RUN    + h*HALF_STRIDE));
    assign wr_rld[h]     = bus_wr && (bus_addr == AW'(OFF_RELOAD + h*HALF_STRIDE));
    assign pin_sel = (ctrl_q[h].evt_mode && ctrl_q[h].src_nbr) ? ext_in[NUM_HALF-1-h] : ext_in[h];

    tp_in_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (pin_sel),
      .sync_en  (ctrl_q[h].sync_en),
      .inv      (ctrl_q[h].inv),
      .edge_sel (ctrl_q[h].edge_sel),
      .lvl      (lvl[h]),
      .ev       (ev[h])
    );

    assign tick[h] = ctrl_q[h].evt_mode ? ev[h] : (ctrl_q[h].gate_ext ? lvl[h] : 1'b1);

    tp_half #(.W(W)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load[h]),
      .step  (step[h]),
      .wrap  (wrap[h]),
      .up    (up_eff[h]),
      .rld   (rld_q[h]),
      .cnt   (cnt[h]),
      .term  (term[h])
    );
  end

  // Step, load and expiry for the two halves, separate or joined.
  always_comb begin
    run_wr[0] = wr_run_raw[0];
    run_wr[1] = wr_run_raw[1] & ~joined;
    load[0]   = run_wr[0] & cmd_start & ~cmd_stop & cmd_load;
    step[0]   = en_q[0] & tick[0] & ~run_wr[0];
    up_eff[0] = ctrl_q[0].up;
    if (joined) begin
      load[1]   = load[0];
      step[1]   = step[0] & term[0];
      up_eff[1] = ctrl_q[0].up;
      expire[0] = step[0] & term[0] & term[1];
      expire[1] = 1'b0;
      wrap[0]   = expire[0];
      wrap[1]   = expire[0];
    end else begin
      load[1]   = run_wr[1] & cmd_start & ~cmd_stop & cmd_load;
      step[1]   = en_q[1] & tick[1] & ~run_wr[1];
      up_eff[1] = ctrl_q[1].up;
      expire[0] = step[0] & term[0];
      expire[1] = step[1] & term[1];
      wrap      = expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < NUM_HALF; h++) begin
        ctrl_q[h] <= '0;
        rld_q[h]  <= '0;
      end
      en_q   <= '0;
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      for (int h = 0; h < NUM_HALF; h++) begin
        if (wr_ctrl[h]) begin
          ctrl_q[h] <= ctrl_wval;
          if (h != 0) ctrl_q[h].join_b <= 1'b0;
        end
        if (wr_rld[h]) rld_q[h] <= bus_wdata[W-1:0];
        if (run_wr[h]) begin
          if (cmd_stop)       en_q[h] <= 1'b0;
          else if (cmd_start) en_q[h] <= 1'b1;
        end else if (expire[h] && ctrl_q[h].one_shot) begin
          en_q[h] <= 1'b0;
        end
      end
      if (joined) en_q[1] <= 1'b0;
      if (wr_ien) ien_q <= bus_wdata[NUM_HALF-1:0];
      pend_q <= (pend_q & ~(wr_clr ? bus_wdata[NUM_HALF-1:0] : '0)) | expire;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (bus_addr == AW'(OFF_CTRL + h*HALF_STRIDE))
        bus_rdata = DW'({ctrl_q[h], en_q[h]});
      if (bus_addr == AW'(OFF_RELOAD + h*HALF_STRIDE))
        bus_rdata = DW'(rld_q[h]);
      if (bus_addr == AW'(OFF_COUNT + h*HALF_STRIDE))
        bus_rdata = DW'(cnt[h]);
    end
    if (bus_addr == AW'(OFF_IEN))  bus_rdata = DW'(ien_q);
    if (bus_addr == AW'(OFF_PEND)) bus_rdata = DW'(pend_q);
  end

  assign irq = |(pend_q & ien_q);

  logic [CW-1:0] unused_cw;
  assign unused_cw = '0;
endmodule

// File: rtl/tp_pair_chk.sv
module tp_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   run_wr,
  input logic [1:0]   cmd_bits,
  input logic [1:0]   en_q,
  input logic [1:0]   pend_q,
  input logic [1:0]   expire,
  input logic         one_shot_a,
  input logic         joined,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] cnt_b,
  input logic [W-1:0] rld_a,
  input logic         step_a,
  input logic         term_a,
  input logic         load_b
);
  AST_START_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    run_wr[0] && cmd_bits[0] && !cmd_bits[1] |=> en_q[0]); // R5

  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    run_wr[0] && cmd_bits[1] |=> !en_q[0]); // R6

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] && !run_wr[0] |=> $stable(cnt_a)); // R6

  AST_RELOAD_ON_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> cnt_a == $past(rld_a)); // R3

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] && one_shot_a && !run_wr[0] |=> !en_q[0]); // R7

  AST_EXP_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> pend_q[0]); // R12

  AST_JOIN_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    joined && !load_b && !(step_a && term_a) |=> $stable(cnt_b)); // R11

  AST_JOIN_NO_PEND_B: assert property (@(posedge clk) disable iff (!rst_n)
    joined && !pend_q[1] |=> !pend_q[1]); // R11
endmodule

bind tmr_pair16 tp_pair_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_wr     (run_wr),
  .cmd_bits   (bus_wdata[1:0]),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .expire     (expire),
  .one_shot_a (ctrl_q[0].one_shot),
  .joined     (joined),
  .cnt_a      (cnt[0]),
  .cnt_b      (cnt[1]),
  .rld_a      (rld_q[0]),
  .step_a     (step[0]),
  .term_a     (term[0]),
  .load_b     (load[1])
);

// File: tb/tb_tmr_pair16.sv
module tb_tmr_pair16;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_CTRL = 8'h10, B_CTRL = 8'h14, A_RUN = 8'h18, B_RUN = 8'h1C;
  localparam logic [7:0] A_RLD = 8'h20, B_RLD = 8'h24, A_CNT = 8'h28, B_CNT = 8'h2C;
  localparam logic [7:0] IEN = 8'hF4, PEND = 8'hFC;

  typedef struct packed {
    logic        up;
    logic [15:0] rld;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic        pend;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 16'd10,     8'd3, 16'd7,      1'b0},
    '{1'b0, 16'd3,      8'd4, 16'd3,      1'b1},
    '{1'b0, 16'd3,      8'd6, 16'd1,      1'b1},
    '{1'b1, 16'hFFFD,   8'd2, 16'hFFFF,   1'b0},
    '{1'b1, 16'hFFFD,   8'd3, 16'hFFFD,   1'b1},
    '{1'b1, 16'hFFFD,   8'd5, 16'hFFFF,   1'b1},
    '{1'b0, 16'd0,      8'd2, 16'd0,      1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  ext_in = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  tmr_pair16 dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int k, input int times);
    for (int i = 0; i < times; i++) begin
      ext_in[k] = 1'b1; idle(2);
      ext_in[k] = 1'b0; idle(2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk_rd("R1 ctrl A", A_CTRL, 32'h0);
    chk_rd("R1 count A", A_CNT, 32'h0);
    idle(1);
    chk_rd("R1 pending", PEND, 32'h0);
    idle(1);

    // R2 register readback
    wr(A_CTRL, 32'h7FF); chk_rd("R2 ctrl A readback", A_CTRL, 32'h7FE);
    wr(A_CTRL, 32'h0);
    wr(B_CTRL, 32'h7FF); chk_rd("R2 ctrl B readback", B_CTRL, 32'h7EE);
    wr(B_CTRL, 32'h0);
    wr(B_RLD, 32'h12345); chk_rd("R2 reload B readback", B_RLD, 32'h2345);
    chk_rd("R2 run reads zero", A_RUN, 32'h0);
    wr(B_RLD, 32'h0);

    // R3/R4 vector table on half A
    foreach (VECS[i]) begin
      wr(A_RUN, 32'h2);
      wr(A_CTRL, {30'b0, VECS[i].up, 1'b0});
      wr(A_RLD, {16'b0, VECS[i].rld});
      wr(PEND, 32'h3);
      wr(A_RUN, 32'h5);
      idle(int'(VECS[i].n));
      wr(A_RUN, 32'h2);
      chk_rd($sformatf("%s vec%0d count", VECS[i].up ? "R4" : "R3", i), A_CNT, {16'b0, VECS[i].cnt});
      chk_rd($sformatf("%s vec%0d pending", VECS[i].up ? "R4" : "R3", i), PEND, {31'b0, VECS[i].pend});
      idle(1);
    end

    // R5 start with reload, resume, zero-length run
    wr(A_CTRL, 32'h0); wr(A_RLD, 32'd100);
    wr(A_RUN, 32'h5); idle(5); wr(A_RUN, 32'h2);
    chk_rd("R5 loaded run", A_CNT, 32'd95);
    wr(A_RUN, 32'h1); idle(5); wr(A_RUN, 32'h2);
    chk_rd("R5 resume", A_CNT, 32'd90);
    // R6 hold while stopped, stop wins over start
    idle(10);
    chk_rd("R6 held count", A_CNT, 32'd90);
    wr(A_RUN, 32'h3);
    chk_rd("R6 stop wins running flag", A_CTRL, 32'h0);
    wr(A_RUN, 32'h7);
    chk_rd("R6 stop wins no load", A_CNT, 32'd90);
    wr(A_RUN, 32'h5); wr(A_RUN, 32'h2);
    chk_rd("R5 start edge does not step", A_CNT, 32'd100);

    // R7 one-shot
    wr(A_CTRL, 32'h8); wr(A_RLD, 32'd2); wr(PEND, 32'h3);
    wr(A_RUN, 32'h5); idle(10);
    chk_rd("R7 count at reload", A_CNT, 32'd2);
    chk_rd("R7 running cleared", A_CTRL, 32'h8);
    chk_rd("R7 pending set", PEND, 32'h1);
    idle(1);

    // R12 interrupt gating and clear
    chk("R12 irq masked", {31'b0, irq}, 32'h0);
    wr(IEN, 32'h1);
    chk("R12 irq enabled", {31'b0, irq}, 32'h1);
    wr(PEND, 32'h1);
    chk("R12 irq after clear", {31'b0, irq}, 32'h0);
    chk_rd("R12 pending cleared", PEND, 32'h0);
    wr(IEN, 32'h0);

    // R8 edge select and inversion on half A
    ext_in = 2'b00;
    wr(A_CTRL, 32'h46); wr(A_RLD, 32'h0); wr(A_RUN, 32'h5);
    pulse(0, 3);
    chk_rd("R8 rising edges", A_CNT, 32'd3);
    wr(A_CTRL, 32'h86); pulse(0, 3);
    chk_rd("R8 falling edges", A_CNT, 32'd6);
    wr(A_CTRL, 32'hC6); pulse(0, 3);
    chk_rd("R8 both edges", A_CNT, 32'd12);
    wr(A_CTRL, 32'h06); pulse(0, 2);
    chk_rd("R8 no edge", A_CNT, 32'd12);
    ext_in[0] = 1'b1; idle(2);
    wr(A_CTRL, 32'h66); idle(2);
    ext_in[0] = 1'b0; idle(2);
    ext_in[0] = 1'b1; idle(2);
    ext_in[0] = 1'b0; idle(2);
    chk_rd("R8 inverted rising", A_CNT, 32'd14);
    wr(A_CTRL, 32'h46); idle(2);
    ext_in[0] = 1'b1;
    @(negedge clk);
    chk_rd("R8 unsynced latency", A_CNT, 32'd15);
    ext_in[0] = 1'b0; idle(2);

    // R9 synchroniser latency
    wr(A_CTRL, 32'h146); idle(3);
    ext_in[0] = 1'b1;
    @(negedge clk); chk_rd("R9 sync edge 1", A_CNT, 32'd15);
    @(negedge clk); chk_rd("R9 sync edge 2", A_CNT, 32'd15);
    @(negedge clk); chk_rd("R9 sync edge 3", A_CNT, 32'd16);
    ext_in[0] = 1'b0; idle(4);
    wr(A_RUN, 32'h2); wr(A_CTRL, 32'h0);

    // R8 neighbour pin select on half B
    wr(B_CTRL, 32'h446); wr(B_RLD, 32'h0); wr(B_RUN, 32'h5);
    pulse(0, 2); pulse(1, 1);
    chk_rd("R8 neighbour source", B_CNT, 32'd2);
    wr(B_RUN, 32'h2); wr(B_CTRL, 32'h0);

    // R10 gated timer
    ext_in = 2'b00;
    wr(A_CTRL, 32'h200); wr(A_RLD, 32'd50);
    wr(A_RUN, 32'h5); idle(5); wr(A_RUN, 32'h2);
    chk_rd("R10 gate low", A_CNT, 32'd50);
    ext_in[0] = 1'b1;
    wr(A_RUN, 32'h1); idle(5); wr(A_RUN, 32'h2);
    chk_rd("R10 gate high", A_CNT, 32'd45);
    ext_in[0] = 1'b0;

    // R11 joined 32-bit unit
    wr(PEND, 32'h3); wr(A_CTRL, 32'h10);
    wr(A_RLD, 32'h2); wr(B_RLD, 32'h1);
    wr(A_RUN, 32'h5); idle(3); wr(A_RUN, 32'h2);
    chk_rd("R11 low word borrow", A_CNT, 32'hFFFF);
    chk_rd("R11 high word borrow", B_CNT, 32'h0);
    chk_rd("R11 no early expiry", PEND, 32'h0);
    wr(B_RUN, 32'h1);
    chk_rd("R11 half B run ignored", B_CTRL, 32'h0);
    wr(A_RUN, 32'h1); idle(65536); wr(A_RUN, 32'h2);
    chk_rd("R11 low word reload", A_CNT, 32'h2);
    chk_rd("R11 high word reload", B_CNT, 32'h1);
    chk_rd("R11 only pending 0", PEND, 32'h1);
    wr(A_CTRL, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule